// File: doc/BRIEF.md
# Converter Channel Select and Single Conversion Fetch Sequencer

This block is a host-side master for the serial command port of a delta-sigma analog-to-digital converter. One start pulse, together with an 8-bit channel-select value, runs a fixed transaction. The block first writes the channel value into the converter's input-multiplexer register. It then restarts the conversion with a synchronise command and a wake-up command, issues a read-data command, and clocks in the three-byte conversion result. The 24-bit word is presented with a one-cycle valid strobe.

The converter needs idle time after some of its commands before the next serial clock edge. That idle time is counted in converter master clock periods. The sequencer makes every gap from the system clock, using a parameter that sets how many system cycles make up one converter clock period. Each command gets its own gap. The bytes of a single command follow one another at the normal serial clock rate, with no extra wait between them. The serial clock half period is never shorter than two converter clock periods, which keeps the serial clock at or below one quarter of the converter clock.

The serial clock idles low. The data-in line changes on the rising serial clock edge and is read by the converter on the falling edge. The host captures result bits on the falling edge, most significant bit first. Chip select is low for the whole transaction and high otherwise.

Top module: `adc_chan_fetch`

## Requirements
- R1: During and immediately after reset, cs_n_o is 1, sclk_o is 0, din_o is 0, busy_o is 0 and valid_o is 0.
- R2: In a transaction the block sends these bytes on din_o, each most significant bit first, with din_o changing only on a rising edge of sclk_o: 0x51 (upper nibble 0101 = register write, lower nibble = register address 1), 0x00 (one register), the channel byte, 0xFC (synchronise), 0x00 (wake-up), 0x01 (read data).
- R3: Every high phase and every low phase of sclk_o lasts at least 2*CONV_DIV system cycles.
- R4: From the last falling sclk_o edge of the channel data byte to the next rising edge, at least 4*CONV_DIV system cycles pass.
- R5: From the last falling sclk_o edge of the synchronise command to the next rising edge, at least 24*CONV_DIV system cycles pass.
- R6: From the last falling sclk_o edge of the read-data command to the first rising edge that shifts out result data, at least 50*CONV_DIV system cycles pass.
- R7: Between two bytes of the same command, after the wake-up command, and between result bytes, the interval from the last falling edge to the next rising edge is at most SCLK_HALF+4 system cycles.
- R8: cs_n_o goes low before the first rising edge of sclk_o, stays low until after the last falling edge, and then returns high. sclk_o is never high while cs_n_o is high.
- R9: 24 result bits are captured from dout_i on the falling edges of sclk_o, most significant bit first. They appear on result_o while valid_o is high for exactly one cycle, and busy_o falls in that same cycle.
- R10: A start pulse that arrives while busy_o is high has no effect. The channel byte sent is the first one latched, and only one valid_o pulse is produced.
- R11: busy_o rises in the cycle after an accepted start pulse and stays high until the valid_o cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to run a transaction |
| chan_i | input | 8 | Channel-select value written to the multiplexer register |
| dout_i | input | 1 | Serial data from the converter |
| sclk_o | output | 1 | Serial clock to the converter, idles low |
| din_o | output | 1 | Serial data to the converter |
| cs_n_o | output | 1 | Active-low chip select |
| busy_o | output | 1 | High while a transaction is in progress |
| result_o | output | 24 | Conversion result, most significant byte first on the wire |
| valid_o | output | 1 | One-cycle strobe marking result_o as new |

## Verification
The bench runs full transactions with several channel and result patterns:
- Channel 0x58 with result 0xA5C3F0 exposes bit-order and byte-order swaps, because every nibble differs.
- Channel 0x01 with result 0x800001 isolates the two end bits of the 24-bit word.
- Channel 0xFF with result 0xFFFFFF and channel 0x00 with result 0x000000 show stuck-at faults on din_o and on capture.

A converter model in the bench timestamps every serial clock edge. From these timestamps it measures the three command-specific gaps, the short intra-command intervals and the minimum phase width. A second start pulse issued mid-transaction with a different channel shows whether busy requests are really ignored.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

  // command encodings seen by the converter
  localparam logic [3:0] OP_WRITE_HI = 4'b0101;
  localparam logic [7:0] OP_SYNC     = 8'hFC;
  localparam logic [7:0] OP_WAKE     = 8'h00;
  localparam logic [7:0] OP_READ     = 8'h01;

  // minimum idle after a command, in converter clock periods
  localparam int GAP_AFTER_WRITE = 4;
  localparam int GAP_AFTER_SYNC  = 24;
  localparam int GAP_AFTER_READ  = 50;

  // byte slots of one transaction
  localparam int NUM_SLOTS  = 9;
  localparam int FIRST_RX   = 6;
  localparam int SLOT_W     = 4;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_SEND,
    SQ_WAIT,
    SQ_GAP,
    SQ_FIN
  } seq_state_t;

  typedef enum logic [1:0] {
    BE_IDLE,
    BE_LEAD,
    BE_HIGH,
    BE_LOW
  } eng_state_t;

endpackage

// File: rtl/spi_byte_engine.sv
module spi_byte_engine
  import adcseq_pkg::*;
#(
  parameter int HALF = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx
);

  localparam int CW = $clog2(HALF + 1);

  eng_state_t    st;
  logic [CW-1:0] cnt;
  logic [2:0]    bitn;
  logic [7:0]    sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= BE_IDLE;
      cnt  <= '0;
      bitn <= '0;
      sh   <= '0;
      sclk <= 1'b0;
      mosi <= 1'b0;
      done <= 1'b0;
      rx   <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        BE_IDLE: begin
          if (go) begin
            sh  <= tx;
            cnt <= CW'(HALF - 1);
            st  <= BE_LEAD;
          end
        end
        BE_LEAD, BE_LOW: begin
          if (cnt == '0) begin
            sclk <= 1'b1;
            mosi <= sh[7];
            sh   <= {sh[6:0], 1'b0};
            cnt  <= CW'(HALF - 1);
            bitn <= (st == BE_LEAD) ? 3'd0 : bitn + 3'd1;
            st   <= BE_HIGH;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        BE_HIGH: begin
          if (cnt == '0) begin
            sclk <= 1'b0;
            rx   <= {rx[6:0], miso};
            if (bitn == 3'd7) begin
              done <= 1'b1;
              st   <= BE_IDLE;
            end else begin
              cnt <= CW'(HALF - 1);
              st  <= BE_LOW;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= BE_IDLE;
      endcase
    end
  end

  // R3: a high phase is never a single cycle
  assert_sclk_high_hold_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |=> sclk);

  // R2: data line holds still while the clock is high
  assert_mosi_stable_high_R2: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(mosi));

endmodule

// File: rtl/gap_timer.sv
module gap_timer #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         running
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= len;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign running = load || (cnt != '0);

  // R5: a new gap is only started once the previous one has fully elapsed
  assert_gap_no_reload_R5: assert property (@(posedge clk) disable iff (rst)
    load |-> (cnt == '0));

endmodule

// File: rtl/adc_chan_fetch.sv
module adc_chan_fetch
  import adcseq_pkg::*;
#(
  parameter int CONV_DIV  = 4,
  parameter int SCLK_HALF = 8,
  parameter int REG_ADDR  = 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start_i,
  input  logic [7:0]  chan_i,
  input  logic        dout_i,
  output logic        sclk_o,
  output logic        din_o,
  output logic        cs_n_o,
  output logic        busy_o,
  output logic [23:0] result_o,
  output logic        valid_o
);

  localparam int HALF = (SCLK_HALF > 2 * CONV_DIV) ? SCLK_HALF : 2 * CONV_DIV;
  localparam int GW   = $clog2(GAP_AFTER_READ * CONV_DIV + 1);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_SLOTS - 1);

  seq_state_t        st;
  logic [SLOT_W-1:0] slot;
  logic [7:0]        chan_q;
  logic              go;
  logic              gap_load;
  logic              gap_run;
  logic              eng_done;
  logic [7:0]        eng_rx;
  logic [7:0]        tx_byte;
  logic [GW-1:0]     gap_len;

  function automatic logic [GW-1:0] gap_of(input logic [SLOT_W-1:0] s);
    case (s)
      4'd2:    gap_of = GW'(GAP_AFTER_WRITE * CONV_DIV);
      4'd3:    gap_of = GW'(GAP_AFTER_SYNC * CONV_DIV);
      4'd5:    gap_of = GW'(GAP_AFTER_READ * CONV_DIV);
      default: gap_of = '0;
    endcase
  endfunction

  always_comb begin
    case (slot)
      4'd0:    tx_byte = {OP_WRITE_HI, 4'(REG_ADDR)};
      4'd1:    tx_byte = 8'h00;
      4'd2:    tx_byte = chan_q;
      4'd3:    tx_byte = OP_SYNC;
      4'd4:    tx_byte = OP_WAKE;
      4'd5:    tx_byte = OP_READ;
      default: tx_byte = 8'h00;
    endcase
  end

  assign gap_len = gap_of(slot);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SQ_IDLE;
      slot     <= '0;
      chan_q   <= '0;
      go       <= 1'b0;
      gap_load <= 1'b0;
      busy_o   <= 1'b0;
      cs_n_o   <= 1'b1;
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      go       <= 1'b0;
      gap_load <= 1'b0;
      valid_o  <= 1'b0;
      case (st)
        SQ_IDLE: begin
          if (start_i) begin
            chan_q <= chan_i;
            slot   <= '0;
            busy_o <= 1'b1;
            cs_n_o <= 1'b0;
            st     <= SQ_SEND;
          end
        end
        SQ_SEND: begin
          go <= 1'b1;
          st <= SQ_WAIT;
        end
        SQ_WAIT: begin
          if (eng_done) begin
            if (slot >= SLOT_W'(FIRST_RX)) begin
              result_o <= {result_o[15:0], eng_rx};
            end
            if (slot == LAST) begin
              st <= SQ_FIN;
            end else if (gap_len != '0) begin
              gap_load <= 1'b1;
              st       <= SQ_GAP;
            end else begin
              slot <= slot + 1'b1;
              st   <= SQ_SEND;
            end
          end
        end
        SQ_GAP: begin
          if (!gap_run) begin
            slot <= slot + 1'b1;
            st   <= SQ_SEND;
          end
        end
        SQ_FIN: begin
          valid_o <= 1'b1;
          busy_o  <= 1'b0;
          cs_n_o  <= 1'b1;
          st      <= SQ_IDLE;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  spi_byte_engine #(.HALF(HALF)) u_eng (
    .clk  (clk),
    .rst  (rst),
    .go   (go),
    .tx   (tx_byte),
    .miso (dout_i),
    .sclk (sclk_o),
    .mosi (din_o),
    .done (eng_done),
    .rx   (eng_rx)
  );

  gap_timer #(.W(GW)) u_gap (
    .clk     (clk),
    .rst     (rst),
    .load    (gap_load),
    .len     (gap_len),
    .running (gap_run)
  );

  assert_cs_idle_clock_low_R8: assert property (@(posedge clk) disable iff (rst)
    cs_n_o |-> !sclk_o);

  assert_valid_ends_busy_R9: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> !busy_o);

  assert_busy_until_valid_R11: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> (busy_o || valid_o));

  assert_late_start_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> $stable(chan_q));

endmodule

// File: tb/sim_adc_chan_fetch.sv
`timescale 1ns/1ps
module sim_adc_chan_fetch;

  localparam int CONV_DIV  = 4;
  localparam int SCLK_HALF = 8;
  localparam real TCLK = 10.0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [7:0]  chan_i = '0;
  logic        dout_i = 1'b0;
  logic        sclk_o, din_o, cs_n_o, busy_o, valid_o;
  logic [23:0] result_o;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  adc_chan_fetch #(.CONV_DIV(CONV_DIV), .SCLK_HALF(SCLK_HALF), .REG_ADDR(1)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .chan_i(chan_i), .dout_i(dout_i),
    .sclk_o(sclk_o), .din_o(din_o), .cs_n_o(cs_n_o), .busy_o(busy_o),
    .result_o(result_o), .valid_o(valid_o)
  );

  // converter model
  int          rise_n = 0;
  int          fall_n = 0;
  logic [23:0] pat = '0;
  logic [7:0]  got [0:8];
  realtime     first_rise [0:8];
  realtime     last_fall [0:8];
  realtime     last_edge = -1.0;
  realtime     min_w = 1.0e9;
  int          cs_bad = 0;
  int          valids = 0;

  always @(posedge sclk_o) begin
    if (rise_n >= 48 && rise_n < 72) dout_i = pat[71 - rise_n];
    if (rise_n < 72 && (rise_n % 8) == 0) first_rise[rise_n / 8] = $realtime;
    if (cs_n_o) cs_bad++;
    if (last_edge >= 0.0 && ($realtime - last_edge) < min_w) min_w = $realtime - last_edge;
    last_edge = $realtime;
    rise_n++;
  end

  always @(negedge sclk_o) begin
    if (fall_n < 72) begin
      got[fall_n / 8] = {got[fall_n / 8][6:0], din_o};
      if ((fall_n % 8) == 7) last_fall[fall_n / 8] = $realtime;
    end
    if (cs_n_o) cs_bad++;
    if (($realtime - last_edge) < min_w) min_w = $realtime - last_edge;
    last_edge = $realtime;
    fall_n++;
  end

  always @(posedge clk) if (valid_o) valids++;

  task automatic check(input string req, input logic ok, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_model(input logic [23:0] p);
    rise_n = 0; fall_n = 0; pat = p; last_edge = -1.0; min_w = 1.0e9;
    cs_bad = 0; valids = 0;
    for (int i = 0; i < 9; i++) got[i] = '0;
  endtask

  function automatic int gap_cyc(input int k);
    return int'((first_rise[k + 1] - last_fall[k]) / TCLK);
  endfunction

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 cs_n", cs_n_o == 1'b1, cs_n_o, 1);
    check("R1 sclk", sclk_o == 1'b0, sclk_o, 0);
    check("R1 din", din_o == 1'b0, din_o, 0);
    check("R1 busy", busy_o == 1'b0, busy_o, 0);
    check("R1 valid", valid_o == 1'b0, valid_o, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 cs_n after release", cs_n_o == 1'b1, cs_n_o, 1);
  endtask

  task automatic t_run(input logic [7:0] ch, input logic [23:0] p, input logic extra_start);
    logic [7:0] exp_b [0:5];
    int n;
    exp_b[0] = 8'h51; exp_b[1] = 8'h00; exp_b[2] = ch;
    exp_b[3] = 8'hFC; exp_b[4] = 8'h00; exp_b[5] = 8'h01;
    clear_model(p);
    @(negedge clk);
    chan_i = ch; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check("R11 busy rises", busy_o == 1'b1, busy_o, 1);
    check("R8 cs low", cs_n_o == 1'b0, cs_n_o, 0);
    if (extra_start) begin
      repeat (200) @(negedge clk);
      chan_i = ~ch; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      check("R10 busy kept", busy_o == 1'b1, busy_o, 1);
    end
    n = 0;
    while (!valid_o && n < 20000) begin
      @(negedge clk);
      n++;
      if (!valid_o && busy_o !== 1'b1) begin
        check("R11 busy held", 1'b0, busy_o, 1);
        break;
      end
    end
    check("R9 valid seen", valid_o == 1'b1, valid_o, 1);
    check("R9 result", result_o == p, result_o, p);
    check("R9 busy falls with valid", busy_o == 1'b0, busy_o, 0);
    check("R8 cs high at end", cs_n_o == 1'b1, cs_n_o, 1);
    @(negedge clk);
    check("R9 valid one cycle", valid_o == 1'b0, valid_o, 0);
    for (int i = 0; i < 6; i++)
      check($sformatf("R2 byte %0d", i), got[i] == exp_b[i], got[i], exp_b[i]);
    check("R2 bit count", fall_n == 72, fall_n, 72);
    check("R3 min phase", min_w >= 2.0 * CONV_DIV * TCLK - 0.1, longint'(min_w), 2 * CONV_DIV * 10);
    check("R4 gap after write", gap_cyc(2) >= 4 * CONV_DIV, gap_cyc(2), 4 * CONV_DIV);
    check("R5 gap after sync", gap_cyc(3) >= 24 * CONV_DIV, gap_cyc(3), 24 * CONV_DIV);
    check("R6 gap after read", gap_cyc(5) >= 50 * CONV_DIV, gap_cyc(5), 50 * CONV_DIV);
    check("R7 within write 0", gap_cyc(0) <= SCLK_HALF + 4, gap_cyc(0), SCLK_HALF + 4);
    check("R7 within write 1", gap_cyc(1) <= SCLK_HALF + 4, gap_cyc(1), SCLK_HALF + 4);
    check("R7 after wake", gap_cyc(4) <= SCLK_HALF + 4, gap_cyc(4), SCLK_HALF + 4);
    check("R7 result bytes", gap_cyc(6) <= SCLK_HALF + 4 && gap_cyc(7) <= SCLK_HALF + 4,
          gap_cyc(7), SCLK_HALF + 4);
    check("R8 sclk only with cs low", cs_bad == 0, cs_bad, 0);
    repeat (30) @(negedge clk);
    check("R10 single valid", valids == 1, valids, 1);
    check("R10 idle after run", busy_o == 1'b0 && sclk_o == 1'b0, busy_o, 0);
  endtask

  initial begin
    #(200000 * TCLK);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_run(8'h58, 24'hA5C3F0, 1'b0);
    t_run(8'h01, 24'h800001, 1'b0);
    t_run(8'hFF, 24'hFFFFFF, 1'b0);
    t_run(8'h00, 24'h000000, 1'b0);
    t_run(8'h3C, 24'h5A5A5A, 1'b1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule